// File: doc/BRIEF.md
# Serial-Loadable Stimulus Generator Chain

This block produces the write data, write address, write enable and two read addresses for a 32-word by 32-bit register file with one write and two read ports. Its whole configuration sits in a single serial shift chain. A tester loads that chain one bit per clock while the block is in load mode. It then switches to run mode, where each stimulus group either keeps its loaded value or steps a maximal-length LFSR on every clock.

The chain holds six groups. Five are field groups: two 16-bit halves of the write data, then the write address, read address A and read address B, each 5 bits wide. Each field group has two control bits in front of its field. The last group has one control bit and gates the write enable, whose value comes straight from a dedicated input. While loading, every parallel output is forced to zero, so the register file never sees the moving chain contents. In run mode the control bits stay fixed. A group's output is visible when the global enable is high or when its own enable bit is set. This lets a tester unmask every group but one and then use the global enable to unmask the group under test close to a clock edge.

Top module: `stim_chain_gen`

## Requirements
- R1: A synchronous active-high `rst` clears every chain bit to 0. After reset, `scan_out` is 0, and in run mode every field output is 0.
- R2: While `cfg_run` is 0, each clock shifts the 58-bit chain by one place. `scan_in` enters the write-data-high group's mode bit. `scan_out` is the chain's last bit (the write-enable group's enable bit), so a bit reaches `scan_out` after exactly 58 clocks. From the entry end, the chain reads: mode bit, enable bit, then field MSB to LSB, for each of the five field groups in the order wdata[31:16], wdata[15:0], waddr, raddr A, raddr B. The last bit is the write-enable group's enable bit. So a chain image C[57:0], shifted in C[0] first, puts wdata[31:16] at C[55:40], wdata[15:0] at C[37:22], waddr at C[19:15], raddr A at C[12:8], raddr B at C[5:1], the group mode bits at 57, 39, 21, 14 and 7, the group enable bits at 56, 38, 20, 13 and 6, and the write-enable group's enable bit at 0.
- R3: While `cfg_run` is 0, `rf_wdata`, `rf_waddr`, `rf_raddr_a`, `rf_raddr_b` and `rf_wen` are all 0, whatever `drive_all` and `wr_en_src` are.
- R4: While `cfg_run` is 1, control bits do not change, `scan_in` is ignored and `scan_out` holds.
- R5: In run mode a group whose mode bit is 0 keeps its field value across clocks.
- R6: In run mode a 16-bit group whose mode bit is 1 steps a right-shifting Galois LFSR with mask 0xD008 on each clock: the next state is the state shifted right by one, XORed with the mask when the bit shifted out was 1. So 0x0001 becomes 0xD008 and then 0x6804.
- R7: A 5-bit group steps the same way with mask 0x14. So 0x01 becomes 0x14 and then 0x0A.
- R8: An LFSR field loaded with 0 stays 0. A field loaded with a nonzero value never becomes 0.
- R9: In run mode a group's field appears on its output when `drive_all` is 1 or its enable bit is 1, and reads 0 otherwise.
- R10: `rf_wen` equals `wr_en_src` when `cfg_run` is 1 and either `drive_all` or the write-enable group's enable bit is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_in | input | 1 | Serial chain data in |
| cfg_run | input | 1 | 0: load (shift) mode, 1: run mode |
| drive_all | input | 1 | Global unmask of all group outputs |
| wr_en_src | input | 1 | Source value for the write enable |
| rf_wdata | output | 32 | Write data to the register file |
| rf_waddr | output | 5 | Write address |
| rf_wen | output | 1 | Write enable |
| rf_raddr_a | output | 5 | Read address, port A |
| rf_raddr_b | output | 5 | Read address, port B |
| scan_out | output | 1 | Serial chain data out |

## Verification
The hardest state to reach from the ports is a run-mode configuration where some groups run as LFSRs, others hold, and only some are unmasked. That state exists only after a full 58-bit serial load with the right bit order. The bench therefore builds each chain image from named fields and shifts it in C[0] first, then runs it against a step-by-step model. The frozen control bits are confirmed at the ports by toggling `scan_in` during run mode and then shifting the whole chain back out through `scan_out`.

// File: rtl/sgen_pkg.sv
package sgen_pkg;

  // Behaviour of a field group once the chain leaves load mode.
  typedef enum logic {
    GRP_HOLD = 1'b0,
    GRP_LFSR = 1'b1
  } grp_kind_e;

  // Chain bits taken by one field group: two control bits plus the field.
  function automatic int grp_bits(input int field_w);
    return field_w + 2;
  endfunction

endpackage

// File: rtl/sgen_field_grp.sv
module sgen_field_grp
  import sgen_pkg::*;
#(
  parameter int          W    = 16,
  parameter logic [31:0] POLY = 32'h0000_D008
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         glb_ena,
  input  logic         scan_i,
  output logic         scan_o,
  output logic [W-1:0] val_o
);

  localparam logic [W-1:0] POLY_W = POLY[W-1:0];

  grp_kind_e  kind_q;
  logic       ena_q;
  logic [W-1:0] fld_q;
  logic [W-1:0] fld_step;
  logic       visible;

  // Galois step: shift toward the LSB, fold the mask in when a 1 drops out.
  always_comb begin
    fld_step = {1'b0, fld_q[W-1:1]} ^ (fld_q[0] ? POLY_W : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= GRP_HOLD;
      ena_q  <= 1'b0;
      fld_q  <= '0;
    end else if (!run) begin
      kind_q <= grp_kind_e'(scan_i);
      ena_q  <= kind_q;
      fld_q  <= {ena_q, fld_q[W-1:1]};
    end else if (kind_q == GRP_LFSR) begin
      fld_q  <= fld_step;
    end
  end

  assign scan_o  = fld_q[0];
  assign visible = run && (glb_ena || ena_q);
  assign val_o   = visible ? fld_q : '0;

  assert_load_shift_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (kind_q == grp_kind_e'($past(scan_i))) && (ena_q == $past(kind_q))
             && (fld_q[W-1] == $past(ena_q)));

  assert_ctrl_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(kind_q) && $stable(ena_q));

  assert_hold_field_R5: assert property (@(posedge clk) disable iff (rst)
    (run && kind_q == GRP_HOLD) |=> $stable(fld_q));

  assert_zero_lock_R8: assert property (@(posedge clk) disable iff (rst)
    (run && kind_q == GRP_LFSR && fld_q == '0) |=> (fld_q == '0));

  assert_never_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (run && kind_q == GRP_LFSR && fld_q != '0) |=> (fld_q != '0));

endmodule

// File: rtl/sgen_wen_grp.sv
module sgen_wen_grp (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic glb_ena,
  input  logic wen_src,
  input  logic scan_i,
  output logic scan_o,
  output logic wen_o
);

  logic ena_q;

  always_ff @(posedge clk) begin
    if (rst)       ena_q <= 1'b0;
    else if (!run) ena_q <= scan_i;
  end

  assign scan_o = ena_q;
  assign wen_o  = wen_src && run && (glb_ena || ena_q);

  assert_wen_shift_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> (ena_q == $past(scan_i)));

  assert_wen_frozen_R4: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(ena_q));

endmodule

// File: rtl/stim_chain_gen.sv
module stim_chain_gen
  import sgen_pkg::*;
#(
  parameter int          DATA_W        = 32,
  parameter int          ADDR_W        = 5,
  parameter int          NUM_DATA_GRPS = 2,
  parameter logic [31:0] DATA_POLY     = 32'h0000_D008,
  parameter logic [31:0] ADDR_POLY     = 32'h0000_0014
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_in,
  input  logic              cfg_run,
  input  logic              drive_all,
  input  logic              wr_en_src,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic              rf_wen,
  output logic [ADDR_W-1:0] rf_raddr_a,
  output logic [ADDR_W-1:0] rf_raddr_b,
  output logic              scan_out
);

  localparam int HALF_W        = DATA_W / NUM_DATA_GRPS;
  localparam int NUM_ADDR_GRPS = 3;
  localparam int NUM_FLD_GRPS  = NUM_DATA_GRPS + NUM_ADDR_GRPS;
  localparam int CHAIN_LEN     = NUM_DATA_GRPS * grp_bits(HALF_W)
                               + NUM_ADDR_GRPS * grp_bits(ADDR_W) + 1;

  logic              link [NUM_FLD_GRPS+1];
  logic [ADDR_W-1:0] addr_val [NUM_ADDR_GRPS];

  assign link[0] = scan_in;

  // Write-data slices, most significant slice first in the chain.
  for (genvar gi = 0; gi < NUM_DATA_GRPS; gi++) begin : g_data
    sgen_field_grp #(.W(HALF_W), .POLY(DATA_POLY)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .run    (cfg_run),
      .glb_ena(drive_all),
      .scan_i (link[gi]),
      .scan_o (link[gi+1]),
      .val_o  (rf_wdata[DATA_W-1-gi*HALF_W -: HALF_W])
    );
  end

  // Address groups: write address, read address A, read address B.
  for (genvar ai = 0; ai < NUM_ADDR_GRPS; ai++) begin : g_addr
    sgen_field_grp #(.W(ADDR_W), .POLY(ADDR_POLY)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .run    (cfg_run),
      .glb_ena(drive_all),
      .scan_i (link[NUM_DATA_GRPS+ai]),
      .scan_o (link[NUM_DATA_GRPS+ai+1]),
      .val_o  (addr_val[ai])
    );
  end

  assign rf_waddr   = addr_val[0];
  assign rf_raddr_a = addr_val[1];
  assign rf_raddr_b = addr_val[2];

  sgen_wen_grp u_wen (
    .clk    (clk),
    .rst    (rst),
    .run    (cfg_run),
    .glb_ena(drive_all),
    .wen_src(wr_en_src),
    .scan_i (link[NUM_FLD_GRPS]),
    .scan_o (scan_out),
    .wen_o  (rf_wen)
  );

  initial begin
    assert_chain_len_R2: assert (CHAIN_LEN == 58 || DATA_W != 32 || ADDR_W != 5);
  end

  assert_load_masked_R3: assert property (@(posedge clk) disable iff (rst)
    !cfg_run |-> (rf_wdata == '0) && (rf_waddr == '0) && (rf_raddr_a == '0)
                 && (rf_raddr_b == '0) && !rf_wen);

  assert_wen_follow_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_run && drive_all) |-> (rf_wen == wr_en_src));

endmodule

// File: tb/stim_chain_gen_tb_top.sv
module stim_chain_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_in = 1'b0;
  logic        cfg_run = 1'b0;
  logic        drive_all = 1'b0;
  logic        wr_en_src = 1'b0;
  logic [31:0] rf_wdata;
  logic [4:0]  rf_waddr, rf_raddr_a, rf_raddr_b;
  logic        rf_wen, scan_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [57:0] mdl;  // expected chain image, bit 0 nearest scan_out

  always #10 clk = ~clk;  // 50 MHz

  stim_chain_gen dut_i (
    .clk(clk), .rst(rst), .scan_in(scan_in), .cfg_run(cfg_run),
    .drive_all(drive_all), .wr_en_src(wr_en_src), .rf_wdata(rf_wdata),
    .rf_waddr(rf_waddr), .rf_wen(rf_wen), .rf_raddr_a(rf_raddr_a),
    .rf_raddr_b(rf_raddr_b), .scan_out(scan_out)
  );

  typedef struct packed {
    logic [4:0]  modes;   // bit i: group i (0 = wdata high ... 4 = raddr B)
    logic [4:0]  enas;
    logic [31:0] wd;
    logic [4:0]  wa, ra, rb;
    logic        wena, glb, we;
    logic [7:0]  steps;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{5'h00, 5'h00, 32'hDEADBEEF, 5'd3,  5'd7,  5'h1F, 1'b0, 1'b1, 1'b1, 8'd4},
    '{5'h1F, 5'h00, 32'h0001ACE1, 5'd1,  5'h11, 5'h1E, 1'b0, 1'b1, 1'b0, 8'd40},
    '{5'h05, 5'h0A, 32'h12345678, 5'd9,  5'd2,  5'd6,  1'b1, 1'b0, 1'b1, 8'd10},
    '{5'h1F, 5'h00, 32'h00000000, 5'd0,  5'd5,  5'd0,  1'b0, 1'b1, 1'b1, 8'd35},
    '{5'h00, 5'h00, 32'hCAFEF00D, 5'd4,  5'd8,  5'd12, 1'b0, 1'b0, 1'b1, 8'd3},
    '{5'h1F, 5'h1F, 32'hFFFFFFFF, 5'h1F, 5'h10, 5'd1,  1'b1, 1'b0, 1'b1, 8'd64}
  };

  function automatic logic [57:0] mk(input logic [4:0] m, input logic [4:0] e,
      input logic [31:0] wd, input logic [4:0] wa, input logic [4:0] ra,
      input logic [4:0] rb, input logic wena);
    logic [57:0] c;
    c = '0;
    c[57] = m[0]; c[56] = e[0]; c[55:40] = wd[31:16];
    c[39] = m[1]; c[38] = e[1]; c[37:22] = wd[15:0];
    c[21] = m[2]; c[20] = e[2]; c[19:15] = wa;
    c[14] = m[3]; c[13] = e[3]; c[12:8]  = ra;
    c[7]  = m[4]; c[6]  = e[4]; c[5:1]   = rb;
    c[0]  = wena;
    return c;
  endfunction

  function automatic logic [15:0] getf(input logic [57:0] c, input int lsb, input int w);
    logic [15:0] r;
    r = '0;
    for (int k = 0; k < w; k++) r[k] = c[lsb+k];
    return r;
  endfunction

  // Advance one field of the model by its LFSR if its mode bit is set.
  task automatic adv(input int mi, input int lsb, input int w, input logic [15:0] poly);
    logic [15:0] s;
    if (mdl[mi]) begin
      s = getf(mdl, lsb, w);
      if (s[0]) s = (s >> 1) ^ poly;
      else      s = s >> 1;
      for (int k = 0; k < w; k++) mdl[lsb+k] = s[k];
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst)           mdl = '0;
    else if (!cfg_run) mdl = {scan_in, mdl[57:1]};
    else begin
      adv(57, 40, 16, 16'hD008);
      adv(39, 22, 16, 16'hD008);
      adv(21, 15, 5, 16'h0014);
      adv(14, 8, 5, 16'h0014);
      adv(7, 1, 5, 16'h0014);
    end
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic vis(input int ei);
    return cfg_run && (drive_all || mdl[ei]);
  endfunction

  task automatic check_all(input string req);
    logic [31:0] ewd;
    ewd[31:16] = vis(56) ? getf(mdl, 40, 16) : 16'h0;
    ewd[15:0]  = vis(38) ? getf(mdl, 22, 16) : 16'h0;
    chk({req, " wdata"}, 64'(rf_wdata), 64'(ewd));
    chk({req, " waddr"}, 64'(rf_waddr), vis(20) ? 64'(getf(mdl, 15, 5)) : 64'h0);
    chk({req, " raddr_a"}, 64'(rf_raddr_a), vis(13) ? 64'(getf(mdl, 8, 5)) : 64'h0);
    chk({req, " raddr_b"}, 64'(rf_raddr_b), vis(6) ? 64'(getf(mdl, 1, 5)) : 64'h0);
    chk({req, " wen"}, 64'(rf_wen), 64'(wr_en_src && cfg_run && (drive_all || mdl[0])));
    chk({req, " scan_out"}, 64'(scan_out), 64'(mdl[0]));
  endtask

  task automatic load_chain(input logic [57:0] c);
    cfg_run = 1'b0;
    for (int k = 0; k < 58; k++) begin
      scan_in = c[k];
      #2;
      check_all("R3 load masked");
      tick();
    end
    #2;
    chk("R2 chain image", 64'(mdl), 64'(c));
    chk("R2 scan_out after load", 64'(scan_out), 64'(c[0]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mdl = '0;
    // R1: reset with load mode and ones arriving at scan_in
    scan_in = 1'b1;
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0; scan_in = 1'b0; cfg_run = 1'b1; drive_all = 1'b1; wr_en_src = 1'b0;
    #2;
    check_all("R1 reset state");
    chk("R1 scan_out zero", 64'(scan_out), 64'h0);
    wr_en_src = 1'b1; #2;
    chk("R10 wen via drive_all", 64'(rf_wen), 64'h1);
    drive_all = 1'b0; #2;
    chk("R9 R10 wen masked", 64'(rf_wen), 64'h0);

    // R2: a single one reaches scan_out after exactly 58 shifts
    cfg_run = 1'b0; scan_in = 1'b1; tick(); scan_in = 1'b0;
    for (int k = 1; k < 57; k++) tick();
    #2; chk("R2 not yet at 57", 64'(scan_out), 64'h0);
    tick();
    #2; chk("R2 arrives at 58", 64'(scan_out), 64'h1);

    // Table of configurations, each loaded then run against the model
    for (int v = 0; v < 6; v++) begin
      drive_all = TBL[v].glb; wr_en_src = TBL[v].we;
      load_chain(mk(TBL[v].modes, TBL[v].enas, TBL[v].wd, TBL[v].wa,
                    TBL[v].ra, TBL[v].rb, TBL[v].wena));
      cfg_run = 1'b1;
      for (int s = 0; s < int'(TBL[v].steps); s++) begin
        scan_in = s[0];
        #2;
        check_all("R4 R5 R6 R7 R8 R9 R10 run");
        tick();
      end
    end

    // R6/R7: literal LFSR steps
    drive_all = 1'b1;
    load_chain(mk(5'h05, 5'h00, 32'h0001_0000, 5'h01, 5'h00, 5'h00, 1'b0));
    cfg_run = 1'b1;
    tick(); #2;
    chk("R6 first step", 64'(rf_wdata[31:16]), 64'hD008);
    chk("R7 first step", 64'(rf_waddr), 64'h14);
    tick(); #2;
    chk("R6 second step", 64'(rf_wdata[31:16]), 64'h6804);
    chk("R7 second step", 64'(rf_waddr), 64'h0A);
    chk("R5 held field", 64'(rf_wdata[15:0]), 64'h0);

    // R4: scan_in toggles in run mode, then unload and compare bit by bit
    load_chain(mk(5'h1A, 5'h15, 32'hA5A5_0F0F, 5'd19, 5'd3, 5'd30, 1'b1));
    cfg_run = 1'b1;
    for (int s = 0; s < 12; s++) begin
      scan_in = ~s[0]; #2;
      chk("R4 scan_out holds", 64'(scan_out), 64'h1);
      tick();
    end
    cfg_run = 1'b0; scan_in = 1'b0;
    for (int k = 0; k < 58; k++) begin
      #2; chk("R4 unload", 64'(scan_out), 64'(mdl[0]));
      tick();
    end

    // R1: reset in run mode clears loaded fields
    load_chain(mk(5'h00, 5'h1F, 32'h8765_4321, 5'd7, 5'd8, 5'd9, 1'b1));
    cfg_run = 1'b1; #2;
    check_all("R9 local enables");
    rst = 1'b1; tick(); rst = 1'b0; #2;
    check_all("R1 reset mid-run");
    chk("R1 wdata cleared", 64'(rf_wdata), 64'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule